// File: doc/BRIEF.md
# Sector Error Correction Applier

This block sits behind a four-error syndrome decoder and writes its findings back into a 512-byte sector buffer. After a `start` pulse it first checks whether the ten stored code bytes are all 0xFF. If they are, the sector counts as never programmed and it finishes at once without correcting anything. Otherwise it waits for the decoder and reads the decoder's verdict. If the decoder has located errors, the block unpacks up to four location/value entries from two location words and two value words. It converts each location into a byte offset and patches the buffer with a read-modify-write XOR through a byte-wide synchronous port.

Decoder locations count backward from the end of the protected area. A location that maps outside the 512 data bytes falls in the code bytes and is skipped. The block ends every job with a one-cycle `done` pulse. The pulse carries the number of bytes actually patched and a flag marking a sector with too many errors to fix.

Top module: `ecc_fix_sequencer`

## Requirements
- R1: When `start` is sampled and all ten bytes of `code_bytes` equal 0xFF, `done` rises on the next cycle with `fix_count` 0 and `uncorrectable` 0, and no buffer write occurs. A single byte differing from 0xFF makes the job run normally.
- R2: Decoder state 0 (no error) ends the job with `fix_count` 0, `uncorrectable` 0 and no buffer write.
- R3: Decoder state 1 (five or more errors) ends the job with `uncorrectable` 1, `fix_count` 0 and no buffer write.
- R4: After `start`, a decoder state below 4 is not acted on until a state of 4 or above has been seen, or until WAIT_CYCLES cycles have passed. With the state held at 0 from `start` onward and no busy state ever seen, `done` rises on the WAIT_CYCLES+1-th clock edge after the edge that sampled `start`.
- R5: Decoder states of 4 and above mean busy and hold the block waiting. States 2 and 3 mean ready, and the number of entries processed is `dec_cnt`+1.
- R6: Entries 0 and 1 come from `loc_word_lo`/`val_word_lo`, and entries 2 and 3 come from `loc_word_hi`/`val_word_hi`. Even entries use bits 15:0 of a word and odd entries use bits 31:16. Entries are applied in the order 0 to 3.
- R7: The location is the low 10 bits of its 16-bit half, and the byte offset is 519 minus that location.
- R8: For an offset below 512, the buffer byte at that offset is replaced by itself XOR bits 7:0 of the value half. This is done by a read strobe and, two cycles later, a write strobe at the same address. The two strobes are never high together.
- R9: Entries whose offset is not below 512 are skipped. `fix_count` reports only applied entries, so it never exceeds 4.
- R10: `done` is a one-cycle pulse. After reset `done`, `buf_rd_en`, `buf_wr_en`, `fix_count` and `uncorrectable` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a correction job |
| code_bytes | input | 80 | The ten stored code bytes of the sector |
| dec_state | input | 4 | Decoder state: 0 clean, 1 overflow, 2/3 ready, 4+ busy |
| dec_cnt | input | 2 | Error count minus one |
| loc_word_lo | input | 32 | Locations of entries 0 (low half) and 1 (high half) |
| loc_word_hi | input | 32 | Locations of entries 2 (low half) and 3 (high half) |
| val_word_lo | input | 32 | Values of entries 0 and 1 |
| val_word_hi | input | 32 | Values of entries 2 and 3 |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_rd_en | output | 1 | Buffer read strobe, data returned next cycle |
| buf_rdata | input | 8 | Buffer read data |
| buf_wr_en | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |
| done | output | 1 | Job finished, one cycle |
| fix_count | output | 3 | Bytes corrected in the finished job |
| uncorrectable | output | 1 | Sector had too many errors |

## Verification
The busy-wait timeout can expire in the same cycle that the decoder is already showing a final state, because the decoder may never show a busy state at all. The bench holds a final state steady from `start` onward with no busy phase. It then judges that `done` appears exactly WAIT_CYCLES+1 edges after `start` for state 0, and no earlier than that for a ready state, whose patch must still land. In a separate run, a busy state held well past the timeout length shows that the busy condition, not the timer, governs once it has been observed.

// File: rtl/efs_pkg.sv
package efs_pkg;
  typedef enum logic [2:0] {
    FS_IDLE, FS_BUSY, FS_POLL, FS_SEL, FS_RD, FS_RDW, FS_WR, FS_WRW
  } fs_state_t;

  localparam logic [3:0] DEC_CLEAN    = 4'd0;
  localparam logic [3:0] DEC_OVERFLOW = 4'd1;
  localparam logic [3:0] DEC_BUSY_MIN = 4'd4;
endpackage

// File: rtl/efs_erased_detect.sv
module efs_erased_detect #(
  parameter int CODE_BYTES = 10
) (
  input  logic [CODE_BYTES*8-1:0] code,
  output logic                    erased
);
  logic [CODE_BYTES-1:0] byte_ff;

  for (genvar g = 0; g < CODE_BYTES; g++) begin : g_byte
    assign byte_ff[g] = (code[g*8 +: 8] == 8'hFF);
  end

  assign erased = &byte_ff;
endmodule

// File: rtl/efs_entry_sel.sv
module efs_entry_sel #(
  parameter int DATA_BYTES = 512,
  parameter int LOC_BITS   = 10
) (
  input  logic [1:0]                      idx,
  input  logic [31:0]                     loc_lo,
  input  logic [31:0]                     loc_hi,
  input  logic [31:0]                     val_lo,
  input  logic [31:0]                     val_hi,
  output logic [$clog2(DATA_BYTES)-1:0]   off,
  output logic [7:0]                      val,
  output logic                            hit
);
  localparam int OFF_W = $clog2(DATA_BYTES);
  localparam int DW    = LOC_BITS + 2;
  localparam int BIAS  = DATA_BYTES + 7;

  logic [31:0]   loc_word, val_word;
  logic [15:0]   loc_half, val_half;
  logic [DW-1:0] span;

  always_comb begin
    loc_word = idx[1] ? loc_hi : loc_lo;
    val_word = idx[1] ? val_hi : val_lo;
    loc_half = idx[0] ? loc_word[31:16] : loc_word[15:0];
    val_half = idx[0] ? val_word[31:16] : val_word[15:0];
    span     = DW'(BIAS) - {2'b00, loc_half[LOC_BITS-1:0]};
    hit      = !span[DW-1] && (span < DW'(DATA_BYTES));
    off      = span[OFF_W-1:0];
    val      = val_half[7:0];
  end
endmodule

// File: rtl/efs_wait_timer.sv
module efs_wait_timer #(
  parameter int WAIT_CYCLES = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(WAIT_CYCLES + 1);

  logic [CW-1:0] cnt;

  assign expired = run && (cnt == CW'(WAIT_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) cnt <= '0;
    else if (run && !expired) cnt <= cnt + 1'b1;
  end

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(WAIT_CYCLES)); // R4
endmodule

// File: rtl/ecc_fix_sequencer.sv
module ecc_fix_sequencer #(
  parameter int DATA_BYTES  = 512,
  parameter int CODE_BYTES  = 10,
  parameter int LOC_BITS    = 10,
  parameter int WAIT_CYCLES = 64
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [CODE_BYTES*8-1:0]       code_bytes,
  input  logic [3:0]                    dec_state,
  input  logic [1:0]                    dec_cnt,
  input  logic [31:0]                   loc_word_lo,
  input  logic [31:0]                   loc_word_hi,
  input  logic [31:0]                   val_word_lo,
  input  logic [31:0]                   val_word_hi,
  output logic [$clog2(DATA_BYTES)-1:0] buf_addr,
  output logic                          buf_rd_en,
  input  logic [7:0]                    buf_rdata,
  output logic                          buf_wr_en,
  output logic [7:0]                    buf_wdata,
  output logic                          done,
  output logic [2:0]                    fix_count,
  output logic                          uncorrectable
);
  import efs_pkg::*;

  localparam int OFF_W = $clog2(DATA_BYTES);

  fs_state_t        st;
  logic             erased, tmr_expired;
  logic [1:0]       idx, last_idx;
  logic [2:0]       applied;
  logic [7:0]       val_q;
  logic [31:0]      loc_lo_q, loc_hi_q, val_lo_q, val_hi_q;
  logic [OFF_W-1:0] ent_off;
  logic [7:0]       ent_val;
  logic             ent_hit;

  efs_erased_detect #(.CODE_BYTES(CODE_BYTES)) u_erased (
    .code   (code_bytes),
    .erased (erased)
  );

  efs_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (st == FS_IDLE),
    .run     (st == FS_BUSY),
    .expired (tmr_expired)
  );

  efs_entry_sel #(.DATA_BYTES(DATA_BYTES), .LOC_BITS(LOC_BITS)) u_sel (
    .idx    (idx),
    .loc_lo (loc_lo_q),
    .loc_hi (loc_hi_q),
    .val_lo (val_lo_q),
    .val_hi (val_hi_q),
    .off    (ent_off),
    .val    (ent_val),
    .hit    (ent_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= FS_IDLE;
      idx           <= '0;
      last_idx      <= '0;
      applied       <= '0;
      val_q         <= '0;
      loc_lo_q      <= '0;
      loc_hi_q      <= '0;
      val_lo_q      <= '0;
      val_hi_q      <= '0;
      buf_addr      <= '0;
      buf_rd_en     <= 1'b0;
      buf_wr_en     <= 1'b0;
      buf_wdata     <= '0;
      done          <= 1'b0;
      fix_count     <= '0;
      uncorrectable <= 1'b0;
    end else begin
      done      <= 1'b0;
      buf_rd_en <= 1'b0;
      buf_wr_en <= 1'b0;
      unique case (st)
        FS_IDLE: if (start) begin
          if (erased) begin
            done          <= 1'b1;
            fix_count     <= '0;
            uncorrectable <= 1'b0;
          end else begin
            st <= FS_BUSY;
          end
        end
        FS_BUSY: if (dec_state >= DEC_BUSY_MIN || tmr_expired) st <= FS_POLL;
        FS_POLL: begin
          if (dec_state == DEC_CLEAN || dec_state == DEC_OVERFLOW) begin
            done          <= 1'b1;
            fix_count     <= '0;
            uncorrectable <= (dec_state == DEC_OVERFLOW);
            st            <= FS_IDLE;
          end else if (dec_state < DEC_BUSY_MIN) begin
            loc_lo_q <= loc_word_lo;
            loc_hi_q <= loc_word_hi;
            val_lo_q <= val_word_lo;
            val_hi_q <= val_word_hi;
            last_idx <= dec_cnt;
            idx      <= '0;
            applied  <= '0;
            st       <= FS_SEL;
          end
        end
        FS_SEL: begin
          if (ent_hit) begin
            buf_addr  <= ent_off;
            val_q     <= ent_val;
            buf_rd_en <= 1'b1;
            st        <= FS_RD;
          end else if (idx == last_idx) begin
            done          <= 1'b1;
            fix_count     <= applied;
            uncorrectable <= 1'b0;
            st            <= FS_IDLE;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        FS_RD:  st <= FS_RDW;
        FS_RDW: begin
          buf_wdata <= buf_rdata ^ val_q;
          buf_wr_en <= 1'b1;
          st        <= FS_WR;
        end
        FS_WR: begin
          applied <= applied + 1'b1;
          st      <= FS_WRW;
        end
        FS_WRW: begin
          if (idx == last_idx) begin
            done          <= 1'b1;
            fix_count     <= applied;
            uncorrectable <= 1'b0;
            st            <= FS_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= FS_SEL;
          end
        end
        default: st <= FS_IDLE;
      endcase
    end
  end

  AST_WR_FOLLOWS_RD: assert property (@(posedge clk) disable iff (rst)
    buf_wr_en |-> ($past(buf_rd_en, 2) && buf_addr == $past(buf_addr, 2))); // R8

  AST_NO_RW_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(buf_rd_en && buf_wr_en)); // R8

  AST_UNCORR_NO_FIX: assert property (@(posedge clk) disable iff (rst)
    (done && uncorrectable) |-> (fix_count == 3'd0)); // R3

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    done |-> (fix_count <= 3'd4)); // R9

  AST_NO_ACCESS_IDLE: assert property (@(posedge clk) disable iff (rst)
    (st == FS_IDLE || st == FS_BUSY || st == FS_POLL) |-> !buf_wr_en); // R5
endmodule

// File: tb/ecc_fix_sequencer_tb.sv
`timescale 1ns/1ps
module ecc_fix_sequencer_tb;
  localparam int WAIT = 16;
  localparam int NB   = 512;

  typedef struct packed {
    logic [3:0]  fin;
    logic [1:0]  cnt;
    logic [31:0] la, lb, va, vb;
    logic [3:0]  busy;
    logic [2:0]  exp_n;
    logic        exp_u;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{4'd2, 2'd0, 32'h0000_01FD, 32'h0, 32'h0000_0011, 32'h0, 4'd2, 3'd1, 1'b0},
    '{4'd3, 2'd3, 32'h01A3_0207, 32'h0008_00DB, 32'h0022_0001, 32'h0080_00FF, 4'd3, 3'd4, 1'b0},
    '{4'd2, 2'd2, 32'hFD05_0003, 32'h0100_0300, 32'h0055_0044, 32'h0077_0066, 4'd1, 3'd1, 1'b0},
    '{4'd1, 2'd3, 32'h01A3_0207, 32'h0008_00DB, 32'h0022_0001, 32'h0080_00FF, 4'd2, 3'd0, 1'b1},
    '{4'd0, 2'd1, 32'h01A3_0207, 32'h0, 32'h0022_0001, 32'h0, 4'd1, 3'd0, 1'b0},
    '{4'd3, 2'd1, 32'h0107_0107, 32'h0, 32'h00F0_000F, 32'h0, 4'd4, 3'd2, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        start;
  logic [79:0] code_bytes;
  logic [3:0]  dec_state;
  logic [1:0]  dec_cnt;
  logic [31:0] loc_word_lo, loc_word_hi, val_word_lo, val_word_hi;
  logic [8:0]  buf_addr;
  logic        buf_rd_en, buf_wr_en;
  logic [7:0]  buf_rdata, buf_wdata;
  logic        done, uncorrectable;
  logic [2:0]  fix_count;

  logic [7:0]  mem    [NB];
  logic [7:0]  golden [NB];
  int          wr_seen;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  ecc_fix_sequencer #(.WAIT_CYCLES(WAIT)) u_dut (
    .clk(clk), .rst(rst), .start(start), .code_bytes(code_bytes),
    .dec_state(dec_state), .dec_cnt(dec_cnt),
    .loc_word_lo(loc_word_lo), .loc_word_hi(loc_word_hi),
    .val_word_lo(val_word_lo), .val_word_hi(val_word_hi),
    .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_rdata(buf_rdata),
    .buf_wr_en(buf_wr_en), .buf_wdata(buf_wdata),
    .done(done), .fix_count(fix_count), .uncorrectable(uncorrectable)
  );

  always @(posedge clk) begin
    if (buf_rd_en) buf_rdata <= mem[buf_addr];
    if (buf_wr_en) begin
      mem[buf_addr] <= buf_wdata;
      wr_seen <= wr_seen + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected buffer contents, from R6..R9
  function automatic int model(input logic [3:0] fin, input logic [1:0] cnt,
      input logic [31:0] la, input logic [31:0] lb,
      input logic [31:0] va, input logic [31:0] vb);
    int n = 0;
    if (fin == 4'd2 || fin == 4'd3) begin
      for (int k = 0; k <= int'(cnt); k++) begin
        logic [31:0] lw, vw;
        logic [15:0] lh, vh;
        int off;
        lw = (k < 2) ? la : lb;
        vw = (k < 2) ? va : vb;
        lh = (k % 2 == 1) ? lw[31:16] : lw[15:0];
        vh = (k % 2 == 1) ? vw[31:16] : vw[15:0];
        off = 519 - int'(lh[9:0]);
        if (off >= 0 && off < NB) begin
          golden[off] = golden[off] ^ vh[7:0];
          n++;
        end
      end
    end
    return n;
  endfunction

  task automatic run_job(input logic [79:0] code, input logic [3:0] fin,
      input logic [1:0] cnt, input logic [31:0] la, input logic [31:0] lb,
      input logic [31:0] va, input logic [31:0] vb, input int busy_len,
      output int lat);
    @(negedge clk);
    code_bytes = code; dec_cnt = cnt;
    loc_word_lo = la; loc_word_hi = lb; val_word_lo = va; val_word_hi = vb;
    dec_state = (busy_len > 0) ? 4'd9 : fin;
    wr_seen = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 3000) begin
      if (lat >= busy_len) dec_state = fin;
      @(negedge clk);
      lat++;
    end
  endtask

  function automatic int mem_diffs();
    int d = 0;
    for (int i = 0; i < NB; i++) if (mem[i] !== golden[i]) d++;
    return d;
  endfunction

  localparam logic [79:0] ALL_FF = {10{8'hFF}};
  localparam logic [79:0] PROG   = {{9{8'hFF}}, 8'hFE};

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lat;
    int n;
    for (int i = 0; i < NB; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      golden[i] = 8'(i) ^ 8'h5A;
    end
    rst = 1'b1; start = 1'b0; code_bytes = PROG; dec_state = 4'd9; dec_cnt = '0;
    loc_word_lo = '0; loc_word_hi = '0; val_word_lo = '0; val_word_hi = '0;
    wr_seen = 0;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(done === 1'b0 && buf_rd_en === 1'b0 && buf_wr_en === 1'b0,
        "R10 reset strobes", int'({done, buf_rd_en, buf_wr_en}), 0);
    chk(fix_count === 3'd0 && uncorrectable === 1'b0,
        "R10 reset result", int'({uncorrectable, fix_count}), 0);
    rst = 1'b0;

    // Table walk: R2 R3 R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      n = model(VECS[v].fin, VECS[v].cnt, VECS[v].la, VECS[v].lb, VECS[v].va, VECS[v].vb);
      run_job(PROG, VECS[v].fin, VECS[v].cnt, VECS[v].la, VECS[v].lb,
              VECS[v].va, VECS[v].vb, int'(VECS[v].busy), lat);
      chk(done === 1'b1, "R5 done reached", int'(done), 1);
      chk(fix_count == VECS[v].exp_n && n == int'(VECS[v].exp_n),
          "R9 corrected count", int'(fix_count), int'(VECS[v].exp_n));
      chk(uncorrectable == VECS[v].exp_u, "R3 uncorrectable flag",
          int'(uncorrectable), int'(VECS[v].exp_u));
      chk(mem_diffs() == 0, "R8 buffer contents (R6 R7)", mem_diffs(), 0);
      chk(wr_seen == int'(VECS[v].exp_n), "R2 write count", wr_seen, int'(VECS[v].exp_n));
      @(negedge clk);
      chk(done === 1'b0, "R10 done single cycle", int'(done), 0);
    end

    // R1: erased sector, decoder would report a fixable error
    run_job(ALL_FF, 4'd2, 2'd0, 32'h0000_01FD, 32'h0, 32'h0000_0011, 32'h0, 0, lat);
    chk(lat == 1 && done === 1'b1, "R1 erased latency", lat, 1);
    chk(fix_count == 3'd0 && uncorrectable == 1'b0, "R1 erased result",
        int'({uncorrectable, fix_count}), 0);
    repeat (WAIT + 10) @(negedge clk);
    chk(wr_seen == 0 && mem_diffs() == 0, "R1 erased no write", wr_seen, 0);

    // R4: state 0 from start, never busy -> done on edge WAIT+1 after start edge
    run_job(PROG, 4'd0, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 0, lat);
    chk(lat == WAIT + 2 && done === 1'b1, "R4 timeout latency clean", lat, WAIT + 2);

    // R4: ready state from start, no early action, patch still lands
    n = model(4'd2, 2'd0, 32'h0000_0100, 32'h0, 32'h0000_00A5, 32'h0);
    run_job(PROG, 4'd2, 2'd0, 32'h0000_0100, 32'h0, 32'h0000_00A5, 32'h0, 0, lat);
    chk(lat >= WAIT + 2, "R4 no early ready", lat, WAIT + 2);
    chk(fix_count == 3'd1 && mem_diffs() == 0, "R4 patch after timeout",
        int'(fix_count), n);

    // R5: busy held beyond timeout length keeps the block waiting
    run_job(PROG, 4'd0, 2'd0, 32'h0, 32'h0, 32'h0, 32'h0, 3 * WAIT, lat);
    chk(lat > 3 * WAIT, "R5 busy holds past timeout", lat, 3 * WAIT + 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule